// File: doc/BRIEF.md
# Receive Frame Error Checker

This block sits on the receive path of an Ethernet MAC, behind the byte deserialiser and an upstream CRC unit. It follows a byte-wide receive stream that is delimited by start and end strobes. When a frame closes, it judges the frame for five faults: too short, too long, not a whole number of octets, bad CRC, and a receive error from the PHY. For each closed frame it gives one result: an error vector and a drop decision. It also keeps one saturating statistics counter per fault class.

The upper length limit comes from a programmed setting. The block forces that setting into a legal window before it compares. A mode input controls whether a CRC failure appears in the per-frame result sent downstream. The CRC statistics counter counts every failing frame in either mode. The length count covers every valid byte from the first destination-address byte through the last FCS byte.

Top module: `rx_frame_err_chk`

## Requirements
- R1: After reset, `err_vld` and `drop` are 0 and every error counter reads 0.
- R2: The effective maximum length is `max_len_cfg` clamped into 1518..2048. A setting below 1518 acts as 1518, a setting above 2048 acts as 2048, and any setting in between is used unchanged. Frame length is the number of cycles with `byte_vld` high from the `sof` cycle through the `eof` cycle inclusive. Idle cycles inside a frame are not counted.
- R3: A frame of fewer than 64 bytes sets `err_vec` bit 0 and increments `cnt_short`.
- R4: A frame longer than the effective maximum sets `err_vec` bit 1 and increments `cnt_long`. Bits 0 and 1 are never set together.
- R5: `dribble` high in the `eof` cycle marks an alignment fault. It sets `err_vec` bit 2 and increments `cnt_align`.
- R6: `crc_ok` low in the `eof` cycle always increments `cnt_crc`. It sets `err_vec` bit 3 only when `crc_hide` is 0; when `crc_hide` is 1, bit 3 stays 0.
- R7: `phy_rxer` high in any cycle from `sof` through `eof` sets `err_vec` bit 4 and increments `cnt_rxer`.
- R8: `err_vld` pulses for one cycle, in the cycle after the `eof` cycle. `drop` equals the OR of `err_vec` in that cycle. Outside that pulse, `err_vec` and `drop` are 0. The counters show the increment one cycle after `err_vld`.
- R9: Each counter holds at all-ones instead of wrapping.
- R10: `cnt_clr` zeroes every counter on the next edge. It wins over an increment in the same cycle.
- R11: Bytes, `phy_rxer` and `eof` seen outside a frame have no effect on results or counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A receive byte is present this cycle |
| sof | input | 1 | First cycle of a frame |
| eof | input | 1 | Last cycle of a frame |
| dribble | input | 1 | Trailing bits beyond the last whole octet (sampled with eof) |
| crc_ok | input | 1 | Upstream CRC verdict (sampled with eof) |
| phy_rxer | input | 1 | Receive error from the PHY |
| crc_hide | input | 1 | 1: keep CRC faults out of err_vec and drop |
| max_len_cfg | input | CFG_W | Programmed maximum frame length in bytes |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| err_vld | output | 1 | Per-frame result valid |
| err_vec | output | 5 | {rxer, crc, align, long, short} |
| drop | output | 1 | Frame should be discarded |
| cnt_short | output | CNT_W | Too-short frame count |
| cnt_long | output | CNT_W | Too-long frame count |
| cnt_align | output | CNT_W | Alignment fault count |
| cnt_crc | output | CNT_W | CRC fault count |
| cnt_rxer | output | CNT_W | PHY receive error count |

## Verification
The hardest situations to reach are the length boundaries around the clamped limit. To exercise them, the bench drives frames of exactly 1518, 1519, 2048 and 2049 bytes, with settings below, inside and above the window, so that each clamp edge is crossed from both sides. Counter saturation would take tens of thousands of frames with the default width, so the bench builds the block with a 4-bit counter width and sends twenty one-byte frames. A clear pulse is also placed in the same cycle as a pending increment, to show that the clear takes priority.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
  localparam int unsigned ERR_N = 5;

  typedef struct packed {
    logic rxer;
    logic crc;
    logic align;
    logic too_long;
    logic too_short;
  } rx_err_t;

  typedef enum int unsigned {
    IDX_SHORT = 0,
    IDX_LONG  = 1,
    IDX_ALIGN = 2,
    IDX_CRC   = 3,
    IDX_RXER  = 4
  } err_idx_e;
endpackage

// File: rtl/rxchk_len_clamp.sv
module rxchk_len_clamp #(
  parameter int unsigned CFG_W   = 12,
  parameter int unsigned LIM_LO  = 1518,
  parameter int unsigned LIM_HI  = 2048
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [CFG_W-1:0] eff
);
  localparam logic [CFG_W-1:0] LO_V = CFG_W'(LIM_LO);
  localparam logic [CFG_W-1:0] HI_V = CFG_W'(LIM_HI);

  always_comb begin
    if (cfg < LO_V)      eff = LO_V;
    else if (cfg > HI_V) eff = HI_V;
    else                 eff = cfg;
  end
endmodule

// File: rtl/rxchk_frame_track.sv
module rxchk_frame_track
  import rxchk_pkg::*;
#(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  input  logic             dribble,
  input  logic             crc_ok,
  input  logic             phy_rxer,
  input  logic             crc_hide,
  input  logic [LEN_W-1:0] max_eff,
  output logic             res_vld,
  output rx_err_t          res_vec,
  output logic             res_crc_raw
);
  localparam logic [LEN_W-1:0] LEN_SAT = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] MIN_V   = LEN_W'(MIN_FRAME);

  logic             in_frame_q, in_frame_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             rxer_q, rxer_d;
  logic             active, closing, frame_en;
  logic [LEN_W-1:0] len_base;
  rx_err_t          vec_d;
  logic             crc_raw_d;

  always_comb begin
    active   = sof | in_frame_q;
    closing  = eof & active;
    frame_en = active;
    len_base = sof ? '0 : len_q;
    if (byte_vld && active && (len_base != LEN_SAT)) len_d = len_base + 1'b1;
    else                                             len_d = len_base;
    rxer_d     = (sof ? 1'b0 : rxer_q) | (active & phy_rxer);
    in_frame_d = active & ~eof;

    vec_d     = '0;
    crc_raw_d = 1'b0;
    if (closing) begin
      vec_d.too_short = (len_d < MIN_V);
      vec_d.too_long  = (len_d > max_eff) && !(len_d < MIN_V);
      vec_d.align     = dribble;
      crc_raw_d       = ~crc_ok;
      vec_d.crc       = ~crc_ok & ~crc_hide;
      vec_d.rxer      = rxer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      len_q      <= '0;
      rxer_q     <= 1'b0;
    end else if (frame_en) begin
      in_frame_q <= in_frame_d;
      len_q      <= len_d;
      rxer_q     <= rxer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld     <= 1'b0;
      res_vec     <= '0;
      res_crc_raw <= 1'b0;
    end else begin
      res_vld     <= closing;
      res_vec     <= vec_d;
      res_crc_raw <= crc_raw_d;
    end
  end
endmodule

// File: rtl/rxchk_sat_cnt.sv
module rxchk_sat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt != CNT_MAX));
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/rx_frame_err_chk.sv
module rx_frame_err_chk
  import rxchk_pkg::*;
#(
  parameter int unsigned CFG_W     = 12,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MIN_FRAME = 64,
  parameter int unsigned LIM_LO    = 1518,
  parameter int unsigned LIM_HI    = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  input  logic             dribble,
  input  logic             crc_ok,
  input  logic             phy_rxer,
  input  logic             crc_hide,
  input  logic [CFG_W-1:0] max_len_cfg,
  input  logic             cnt_clr,
  output logic             err_vld,
  output logic [4:0]       err_vec,
  output logic             drop,
  output logic [CNT_W-1:0] cnt_short,
  output logic [CNT_W-1:0] cnt_long,
  output logic [CNT_W-1:0] cnt_align,
  output logic [CNT_W-1:0] cnt_crc,
  output logic [CNT_W-1:0] cnt_rxer
);
  localparam int unsigned LEN_W = CFG_W;

  logic [LEN_W-1:0] max_eff;
  logic             res_vld;
  rx_err_t          res_vec;
  logic             res_crc_raw;
  logic [ERR_N-1:0] inc_vec;
  logic [CNT_W-1:0] cnt_arr [ERR_N];

  rxchk_len_clamp #(
    .CFG_W (CFG_W),
    .LIM_LO(LIM_LO),
    .LIM_HI(LIM_HI)
  ) i_clamp (
    .cfg(max_len_cfg),
    .eff(max_eff)
  );

  rxchk_frame_track #(
    .LEN_W    (LEN_W),
    .MIN_FRAME(MIN_FRAME)
  ) i_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .sof        (sof),
    .eof        (eof),
    .dribble    (dribble),
    .crc_ok     (crc_ok),
    .phy_rxer   (phy_rxer),
    .crc_hide   (crc_hide),
    .max_eff    (max_eff),
    .res_vld    (res_vld),
    .res_vec    (res_vec),
    .res_crc_raw(res_crc_raw)
  );

  always_comb begin
    inc_vec            = '0;
    inc_vec[IDX_SHORT] = res_vld & res_vec.too_short;
    inc_vec[IDX_LONG]  = res_vld & res_vec.too_long;
    inc_vec[IDX_ALIGN] = res_vld & res_vec.align;
    inc_vec[IDX_CRC]   = res_vld & res_crc_raw;
    inc_vec[IDX_RXER]  = res_vld & res_vec.rxer;
  end

  for (genvar g = 0; g < ERR_N; g++) begin : g_cnt
    rxchk_sat_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (inc_vec[g]),
      .clr  (cnt_clr),
      .cnt  (cnt_arr[g])
    );
  end

  always_comb begin
    err_vld   = res_vld;
    err_vec   = res_vec;
    drop      = |res_vec;
    cnt_short = cnt_arr[IDX_SHORT];
    cnt_long  = cnt_arr[IDX_LONG];
    cnt_align = cnt_arr[IDX_ALIGN];
    cnt_crc   = cnt_arr[IDX_CRC];
    cnt_rxer  = cnt_arr[IDX_RXER];
  end
endmodule

// File: rtl/rxchk_checker.sv
module rxchk_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eof,
  input logic             crc_hide,
  input logic             cnt_clr,
  input logic             err_vld,
  input logic [4:0]       err_vec,
  input logic             drop,
  input logic [CNT_W-1:0] cnt_short,
  input logic [CNT_W-1:0] cnt_long,
  input logic [CNT_W-1:0] cnt_crc
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  AST_SHORT_LONG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_vec[0] && err_vec[1])); // R4

  AST_CRC_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && crc_hide) |=> !err_vec[3]); // R6

  AST_VLD_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> $past(eof)); // R8

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld |-> (err_vec == 5'd0 && !drop)); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_short == ALL1 && !cnt_clr) |=> cnt_short == ALL1); // R9

  AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (cnt_long >= $past(cnt_long))); // R9

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_short == '0 && cnt_long == '0 && cnt_crc == '0)); // R10
endmodule

bind rx_frame_err_chk rxchk_checker #(.CNT_W(CNT_W)) i_rxchk_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .eof      (eof),
  .crc_hide (crc_hide),
  .cnt_clr  (cnt_clr),
  .err_vld  (err_vld),
  .err_vec  (err_vec),
  .drop     (drop),
  .cnt_short(cnt_short),
  .cnt_long (cnt_long),
  .cnt_crc  (cnt_crc)
);

// File: tb/test_rx_frame_err_chk.sv
`timescale 1ns/1ps
module test_rx_frame_err_chk;
  localparam int CFG_W = 12;
  localparam int CNT_W = 4;
  localparam int CMAX  = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic byte_vld, sof, eof, dribble, crc_ok, phy_rxer, crc_hide, cnt_clr;
  logic [CFG_W-1:0] max_len_cfg;
  logic err_vld, drop;
  logic [4:0] err_vec;
  logic [CNT_W-1:0] cnt_short, cnt_long, cnt_align, cnt_crc, cnt_rxer;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mdl [5];

  always #4 clk = ~clk;

  rx_frame_err_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) i_rx_frame_err_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .eof(eof),
    .dribble(dribble), .crc_ok(crc_ok), .phy_rxer(phy_rxer), .crc_hide(crc_hide),
    .max_len_cfg(max_len_cfg), .cnt_clr(cnt_clr), .err_vld(err_vld),
    .err_vec(err_vec), .drop(drop), .cnt_short(cnt_short), .cnt_long(cnt_long),
    .cnt_align(cnt_align), .cnt_crc(cnt_crc), .cnt_rxer(cnt_rxer)
  );

  typedef struct packed {
    logic [11:0] len;
    logic [11:0] cfg;
    logic drib;
    logic crcok;
    logic rxer;
    logic hide;
    logic gap;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{12'd64,   12'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000}, // R3 boundary ok
    '{12'd63,   12'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00001}, // R3 short
    '{12'd1518, 12'd0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000}, // R2 low clamp
    '{12'd1519, 12'd0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00010}, // R4 long
    '{12'd1519, 12'd1600, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000}, // R2 in window
    '{12'd2048, 12'd4000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000}, // R2 high clamp
    '{12'd2049, 12'd4095, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00010}, // R4 above clamp
    '{12'd100,  12'd1518, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00100}, // R5
    '{12'd100,  12'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01000}, // R6 reported
    '{12'd100,  12'd1518, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00000}, // R6 hidden
    '{12'd100,  12'd1518, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'b10000}, // R7
    '{12'd10,   12'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'b11101}, // all at once
    '{12'd64,   12'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'b00000}, // R2 idle gap
    '{12'd1,    12'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00001}  // sof==eof
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    byte_vld = 0; sof = 0; eof = 0; dribble = 0; crc_ok = 1; phy_rxer = 0;
  endtask

  task automatic send_frame(input int len, input logic drib, input logic crcok,
                            input logic rxer, input logic hide, input logic gap,
                            input logic [11:0] cfg);
    max_len_cfg = cfg; crc_hide = hide;
    for (int i = 0; i < len; i++) begin
      if (gap && i == 2) begin
        @(negedge clk); idle_inputs();
      end
      @(negedge clk);
      byte_vld = 1; sof = (i == 0); eof = (i == len - 1);
      dribble  = (i == len - 1) && drib;
      crc_ok   = (i == len - 1) ? crcok : 1'b1;
      phy_rxer = rxer && (i == len / 2);
    end
    @(negedge clk); idle_inputs();
  endtask

  task automatic model_update(input logic [4:0] v, input logic crcok);
    if (v[0] && mdl[0] < CMAX) mdl[0]++;
    if (v[1] && mdl[1] < CMAX) mdl[1]++;
    if (v[2] && mdl[2] < CMAX) mdl[2]++;
    if (!crcok && mdl[3] < CMAX) mdl[3]++;
    if (v[4] && mdl[4] < CMAX) mdl[4]++;
  endtask

  task automatic check_counters(input string req);
    check({req, " cnt_short"}, cnt_short, mdl[0]);
    check({req, " cnt_long"},  cnt_long,  mdl[1]);
    check({req, " cnt_align"}, cnt_align, mdl[2]);
    check({req, " cnt_crc"},   cnt_crc,   mdl[3]);
    check({req, " cnt_rxer"},  cnt_rxer,  mdl[4]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 5; k++) mdl[k] = 0;
    rst_n = 0; idle_inputs(); crc_hide = 0; cnt_clr = 0; max_len_cfg = 12'd1518;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 err_vld", err_vld, 0);
    check("R1 drop", drop, 0);
    rst_n = 1;
    @(negedge clk);
    check_counters("R1");

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      send_frame(TBL[v].len, TBL[v].drib, TBL[v].crcok, TBL[v].rxer,
                 TBL[v].hide, TBL[v].gap, TBL[v].cfg);
      check($sformatf("R8 err_vld vec%0d", v), err_vld, 1);
      check($sformatf("R2-table err_vec vec%0d", v), err_vec, TBL[v].exp);
      check($sformatf("R8 drop vec%0d", v), drop, |TBL[v].exp);
      model_update(TBL[v].exp, TBL[v].crcok);
      @(negedge clk);
      check($sformatf("R8 pulse end vec%0d", v), err_vld, 0);
      check_counters($sformatf("R8 vec%0d", v));
    end

    // R11: stray bytes, rxer and eof outside a frame
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); byte_vld = 1; phy_rxer = 1; eof = (i == 59);
    end
    @(negedge clk); idle_inputs();
    check("R11 stray eof", err_vld, 0);
    @(negedge clk);
    check_counters("R11");
    send_frame(64, 0, 1, 0, 0, 0, 12'd1518);
    check("R11 next frame clean", err_vec, 0);
    @(negedge clk);
    check_counters("R11 after");

    // R10 clear
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    for (int k = 0; k < 5; k++) mdl[k] = 0;
    check_counters("R10 clear");

    // R10 clear beats a concurrent increment
    send_frame(5, 0, 1, 0, 0, 0, 12'd1518);
    check("R3 short flag", err_vec, 1);
    cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    check("R10 clear priority", cnt_short, 0);

    // R9 saturation
    for (int n = 0; n < 20; n++) begin
      send_frame(1, 0, 1, 0, 0, 0, 12'd1518);
    end
    @(negedge clk);
    check("R9 saturate", cnt_short, CMAX);
    check("R9 others", cnt_long, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule